// File: doc/BRIEF.md
# Four-Phase Handshake Word Transfer Between Clock Domains

This block carries one data word of any width from a source clock domain to an unrelated destination clock domain. It does not encode the word in any way. The source side latches a word when a send strobe arrives while it is ready. It then raises a request line and holds the latched word unchanged until the whole exchange has closed. The request enters the destination domain through a chain of flip-flops. On the rising edge of the synchronized request, the destination captures the word, emits a one-cycle valid pulse and raises an acknowledge line.

The acknowledge returns to the source through its own synchronizer chain. The source drops the request only after it sees the synchronized acknowledge. The destination drops the acknowledge once the synchronized request has fallen. The source reports ready again only after the synchronized acknowledge has fallen. Each word therefore costs several cycles of both clocks, and in exchange any bus width crosses safely.

Each domain has its own synchronous active-high reset. The synchronizer depth is a parameter with a default of two flip-flops.

Top module: `hs_bus_xfer`

## Requirements
- R1: After reset, `src_ready_o` is 1, `dst_valid_o` is 0 and `dst_data_o` is all zeros.
- R2: A `src_send_i` seen at a source clock edge while `src_ready_o` is 1 accepts `src_data_i`. `src_ready_o` is 0 from the next source cycle onward.
- R3: A `src_send_i` made while `src_ready_o` is 0 is ignored. Its data never appears at `dst_data_o`, and the held word does not change.
- R4: Every accepted word appears at `dst_data_o` exactly once, in the order of acceptance, together with a `dst_valid_o` pulse that lasts one destination cycle.
- R5: Between valid pulses, `dst_data_o` keeps the last delivered word.
- R6: `src_ready_o` returns to 1 only after the accepted word has been delivered. The request falls only after the synchronized acknowledge is seen, and the acknowledge falls only after the synchronized request has fallen.
- R7: Consecutive `dst_valid_o` pulses are at least 2*SYNC_STAGES destination cycles apart.
- R8: After an accept, `src_ready_o` stays 0 for at least 2*SYNC_STAGES source cycles.
- R9: A word reaches `dst_valid_o` no earlier than SYNC_STAGES destination clock edges after the source edge that accepted it. SYNC_STAGES defaults to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst | input | 1 | Source domain synchronous reset, active high |
| src_send_i | input | 1 | Send strobe, honoured only while ready |
| src_data_i | input | DATA_W | Word to send |
| src_ready_o | output | 1 | High when a new word may be accepted |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst | input | 1 | Destination domain synchronous reset, active high |
| dst_valid_o | output | 1 | One-cycle pulse marking a delivered word |
| dst_data_o | output | DATA_W | Last delivered word |

## Verification
On every cycle, the embedded assertions check the handshake ordering on each side:
- the request falls only after the synchronized acknowledge has been seen;
- the acknowledge falls only after the synchronized request has dropped;
- the held word stays stable while the source is busy;
- the valid pulse lasts one cycle;
- the output word stays frozen between pulses.

Only the bench scenarios can show end-to-end properties. These are exactly-once, in-order delivery across the crossing, rejection of strobes made while busy, and the minimum latency and spacing counted in cycles of each clock. The bench runs them with a slow destination clock and again with a fast one.

// File: rtl/hs_bus_xfer_pkg.sv
package hs_bus_xfer_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE  = 2'd0,
    SRC_REQ   = 2'd1,
    SRC_DRAIN = 2'd2
  } src_state_e;
endpackage

// File: rtl/hs_bit_sync.sv
module hs_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hs_src_side.sv
module hs_src_side
  import hs_bus_xfer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_s_i,
  output logic              req_o,
  output logic              ready_o,
  output logic [DATA_W-1:0] hold_o
);
  src_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SRC_IDLE;
      req_o   <= 1'b0;
      ready_o <= 1'b1;
      hold_o  <= '0;
    end else begin
      case (st)
        SRC_IDLE: if (send_i) begin
          hold_o  <= data_i;
          req_o   <= 1'b1;
          ready_o <= 1'b0;
          st      <= SRC_REQ;
        end
        SRC_REQ: if (ack_s_i) begin
          req_o <= 1'b0;
          st    <= SRC_DRAIN;
        end
        SRC_DRAIN: if (!ack_s_i) begin
          ready_o <= 1'b1;
          st      <= SRC_IDLE;
        end
        default: st <= SRC_IDLE;
      endcase
    end
  end

  // R6
  req_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_o) |-> $past(ack_s_i));
  // R6
  ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> !$past(ack_s_i) && !req_o);
  // R2
  busy_when_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> !ready_o);
  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!ready_o && $past(!ready_o)) |-> $stable(hold_o));
endmodule

// File: rtl/hs_dst_side.sv
module hs_dst_side #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_s_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              ack_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic req_prev;
  logic req_rise;

  assign req_rise = req_s_i && !req_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_prev <= 1'b0;
      ack_o    <= 1'b0;
      valid_o  <= 1'b0;
      data_o   <= '0;
    end else begin
      req_prev <= req_s_i;
      valid_o  <= 1'b0;
      if (req_rise) begin
        data_o  <= bus_i;
        valid_o <= 1'b1;
        ack_o   <= 1'b1;
      end else if (!req_s_i) begin
        ack_o <= 1'b0;
      end
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R6
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_o) |-> !$past(req_s_i));
  // R4
  valid_ack_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ack_o);
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(data_o));
endmodule

// File: rtl/hs_bus_xfer.sv
module hs_bus_xfer #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              src_clk,
  input  logic              src_rst,
  input  logic              src_send_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              src_ready_o,
  input  logic              dst_clk,
  input  logic              dst_rst,
  output logic              dst_valid_o,
  output logic [DATA_W-1:0] dst_data_o
);
  logic              req;
  logic              req_s;
  logic              ack;
  logic              ack_s;
  logic [DATA_W-1:0] hold;

  hs_src_side #(.DATA_W(DATA_W)) u_src (
    .clk(src_clk), .rst(src_rst), .send_i(src_send_i), .data_i(src_data_i),
    .ack_s_i(ack_s), .req_o(req), .ready_o(src_ready_o), .hold_o(hold)
  );

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(dst_clk), .rst(dst_rst), .d_i(req), .q_o(req_s)
  );

  hs_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(src_clk), .rst(src_rst), .d_i(ack), .q_o(ack_s)
  );

  hs_dst_side #(.DATA_W(DATA_W)) u_dst (
    .clk(dst_clk), .rst(dst_rst), .req_s_i(req_s), .bus_i(hold),
    .ack_o(ack), .valid_o(dst_valid_o), .data_o(dst_data_o)
  );
endmodule

// File: tb/hs_bus_xfer_bench.sv
`timescale 1ns/1ps
module hs_bus_xfer_bench;
  localparam int W  = 16;
  localparam int SS = 2;

  logic src_clk = 0, dst_clk = 0;
  logic src_rst = 1, dst_rst = 1;
  logic src_send_i = 0;
  logic [W-1:0] src_data_i = '0;
  logic src_ready_o, dst_valid_o;
  logic [W-1:0] dst_data_o;
  realtime dst_half = 10.35;

  int errors = 0, checks = 0;
  logic [W-1:0] exp_q[$];
  int accepted = 0, delivered = 0;
  int dst_edges = 0, mark = 0, gap = 0;
  bit seen_valid = 0, run = 0, done = 0;
  logic [W-1:0] last_word = '0;

  always #4 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;
  always @(posedge dst_clk) dst_edges++;

  hs_bus_xfer #(.DATA_W(W), .SYNC_STAGES(SS)) u_hs_bus_xfer (
    .src_clk(src_clk), .src_rst(src_rst), .src_send_i(src_send_i),
    .src_data_i(src_data_i), .src_ready_o(src_ready_o),
    .dst_clk(dst_clk), .dst_rst(dst_rst), .dst_valid_o(dst_valid_o),
    .dst_data_o(dst_data_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // destination reference model, compared on every destination cycle
  always @(negedge dst_clk) if (run) begin
    gap++;
    if (dst_valid_o) begin
      chk(dst_data_o[W-1] == 1'b0, "R3 ignored word delivered", dst_data_o, 0);
      chk(exp_q.size() > 0, "R4 unexpected delivery", exp_q.size(), 1);
      if (exp_q.size() > 0) begin
        chk(dst_data_o == exp_q[0], "R4 order/value", dst_data_o, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (seen_valid) chk(gap >= 2*SS, "R7 valid spacing", gap, 2*SS);
      chk(dst_edges - mark >= SS, "R9 latency", dst_edges - mark, SS);
      seen_valid = 1;
      gap = 0;
      delivered++;
      last_word = dst_data_o;
    end else begin
      chk(dst_data_o == last_word, "R5 hold between pulses", dst_data_o, last_word);
    end
  end

  // source side: ready only with nothing in flight
  always @(negedge src_clk) if (run && src_ready_o)
    chk(accepted == delivered, "R6 ready before delivery", accepted - delivered, 0);

  task automatic send_one(input logic [W-1:0] w, input int pokes);
    int n;
    int p;
    p = pokes;
    do @(negedge src_clk); while (!src_ready_o);
    src_send_i = 1;
    src_data_i = w;
    @(posedge src_clk);
    mark = dst_edges;
    exp_q.push_back(w);
    accepted++;
    @(negedge src_clk);
    src_send_i = 0;
    chk(src_ready_o == 1'b0, "R2 busy after accept", src_ready_o, 0);
    n = 1;
    forever begin
      @(negedge src_clk);
      src_send_i = 0;
      if (src_ready_o) break;
      n++;
      if (p > 0) begin
        src_send_i = 1;
        src_data_i = {1'b1, w[W-2:0] ^ 15'h2A5A};  // R3 poke while busy
        p--;
      end
    end
    chk(n >= 2*SS, "R8 busy duration", n, 2*SS);
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((exp_q.size() != 0 || !src_ready_o) && t < 5000) begin
      @(negedge src_clk);
      t++;
    end
  endtask

  initial begin
    repeat (6) @(negedge src_clk);
    repeat (6) @(negedge dst_clk);
    src_rst = 0;
    dst_rst = 0;
    @(negedge src_clk);
    // R1 reset state
    chk(src_ready_o == 1'b1, "R1 ready", src_ready_o, 1);
    chk(dst_valid_o == 1'b0, "R1 valid", dst_valid_o, 0);
    chk(dst_data_o == '0, "R1 data", dst_data_o, 0);
    run = 1;
    // fast source, slow destination
    for (int i = 0; i < 20; i++)
      send_one(16'((i * 16'h1357 + 16'h0101) & 16'h7FFF), i % 4);
    drain();
    // slow source, fast destination
    dst_half = 1.85;
    for (int i = 0; i < 20; i++)
      send_one(16'((i * 16'h2468 + 16'h0F0F) & 16'h7FFF), (i + 1) % 3);
    send_one(16'h7FFF, 0);
    send_one(16'h0000, 5);
    drain();
    repeat (10) @(negedge src_clk);
    chk(delivered == accepted, "R4 count exactly once", delivered, accepted);
    chk(exp_q.size() == 0, "R4 queue empty", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge src_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule